// File: doc/BRIEF.md
# Segment-Shift Linear Address Generator

This block turns a segment value and an effective offset into a linear address the way a legacy 16-bit segmented machine does. It is used when the core runs in its compatibility mode. The segment is moved up by four bit positions to form a base, and the zero-extended offset is added to that base. No descriptor table is read. The carry out of the 20-bit base is kept, so the reachable range extends past the first megabyte. Offsets wider than 16 bits are rejected with a fault. The fault carries the stack-fault vector or the general-protection vector, depending on whether the reference is to the stack. When the compatibility flag is clear, the offset passes straight through as the address and no fault is raised.

Requests arrive on a valid/ready stream. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. One register cycle later a response appears: either `out_addr_ok` or `out_fault` goes high, never both. The response stays on the outputs until a rising edge where `out_ready` is high. `in_ready` is high whenever the response register is empty, or when it is being drained in that same cycle. So a stalled consumer holds off the producer without losing or changing any response.

Top module: `seg_linear_addr_gen`

## Requirements
- R1: With `in_compat` high and an offset no wider than 16 bits, `out_addr` equals the segment value times 16 plus the offset.
- R2: The sum keeps its carry above bit 19 with no wrap: segment FFFFh with offset FFFFh gives 10FFEFh.
- R3: In compatibility mode, every `out_addr` bit above bit 20 is zero.
- R4: In compatibility mode, an offset above FFFFh produces `out_fault` high, `out_addr_ok` low and `out_addr` zero.
- R5: A faulting reference with `in_stack` high reports vector 12 (0x0C) on `out_vector`; a faulting reference with `in_stack` low reports 13 (0x0D).
- R6: With `in_compat` low, `out_addr` equals the 32-bit offset unchanged, `out_fault` stays low and the segment has no effect.
- R7: The response to an accepted request is visible from the edge that accepts it, and `out_addr_ok` and `out_fault` are never high together.
- R8: While a response is held and `out_ready` is low, `in_ready` is low, every output is stable and a new request on `in_valid` is not taken.
- R9: After reset there is no response: `out_addr_ok` and `out_fault` are low, `in_ready` is high, `out_addr` and `out_vector` are zero.
- R10: `out_vector` is zero on every non-faulting response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_compat | input | 1 | Compatibility (segment-shift) mode flag |
| in_segment | input | 16 | Segment value |
| in_offset | input | 32 | Effective offset |
| in_stack | input | 1 | Reference is to the stack |
| out_addr_ok | output | 1 | Response holds a good linear address |
| out_fault | output | 1 | Response is a limit fault |
| out_addr | output | 32 | Linear address (zero on fault) |
| out_vector | output | 8 | Exception vector on fault, else zero |
| out_ready | input | 1 | Consumer takes the response this cycle |

## Verification
The state that matters is the one-entry response register. If its payload is corrupted, the address or vector is wrong at the very next negative edge after acceptance. If the occupancy bit is wrong, a response is lost or duplicated. That shows up within one cycle: either `in_ready` rises while `out_ready` is low, or a held response changes under back-pressure. The carry and limit paths are combinational ahead of that register. A wrong carry or a missed limit therefore shows up on the first response for the FFFF:FFFF or the 10000h cases.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int unsigned VEC_W_DEF = 8;
  localparam logic [VEC_W_DEF-1:0] VEC_STACK_FAULT = 8'd12;
  localparam logic [VEC_W_DEF-1:0] VEC_GP_FAULT    = 8'd13;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'b00,
    RESP_ADDR  = 2'b01,
    RESP_FAULT = 2'b10
  } resp_kind_e;
endpackage

// File: rtl/seg_base_adder.sv
module seg_base_adder #(
  parameter int unsigned SEG_W   = 16,
  parameter int unsigned SHIFT   = 4,
  parameter int unsigned LIMIT_W = 16,
  localparam int unsigned SUM_W  = SEG_W + SHIFT + 1
) (
  input  logic [SEG_W-1:0]   seg,
  input  logic [LIMIT_W-1:0] off_lo,
  output logic [SUM_W-1:0]   sum
);
  logic [SUM_W-1:0] base_ext;
  logic [SUM_W-1:0] off_ext;

  assign base_ext = {1'b0, seg, {SHIFT{1'b0}}};
  assign off_ext  = {{(SUM_W-LIMIT_W){1'b0}}, off_lo};
  assign sum      = base_ext + off_ext;
endmodule

// File: rtl/offset_limit_check.sv
module offset_limit_check
  import seg_addr_pkg::*;
#(
  parameter int unsigned OFF_W   = 32,
  parameter int unsigned LIMIT_W = 16,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [OFF_W-1:0] off,
  input  logic             compat,
  input  logic             stack,
  output logic             over,
  output logic [VEC_W-1:0] vector
);
  logic high_bits;

  generate
    if (OFF_W > LIMIT_W) begin : g_has_high
      assign high_bits = |off[OFF_W-1:LIMIT_W];
    end else begin : g_no_high
      assign high_bits = 1'b0;
    end
  endgenerate

  assign over = compat && high_bits;

  always_comb begin
    vector = '0;
    if (over) begin
      vector = stack ? VEC_W'(VEC_STACK_FAULT) : VEC_W'(VEC_GP_FAULT);
    end
  end

  always_comb begin
    a_vec_only_on_fault_r10: assert (over || vector == '0);
  end
endmodule

// File: rtl/resp_stage.sv
module resp_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_valid,
  output logic          load_ready,
  input  logic [DW-1:0] load_data,
  input  logic [1:0]    load_kind,
  output logic [1:0]    hold_kind,
  output logic [DW-1:0] hold_data,
  input  logic          drain
);
  logic          occupied;
  logic          take;

  assign load_ready = !occupied || drain;
  assign take       = load_valid && load_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occupied  <= 1'b0;
      hold_kind <= '0;
      hold_data <= '0;
    end else if (take) begin
      occupied  <= 1'b1;
      hold_kind <= load_kind;
      hold_data <= load_data;
    end else if (drain) begin
      occupied  <= 1'b0;
      hold_kind <= '0;
      hold_data <= '0;
    end
  end

  p_one_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_kind != 2'b11);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occupied && !drain) |=> ($stable(hold_data) && $stable(hold_kind)));

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occupied && !drain) |-> !load_ready);
endmodule

// File: rtl/seg_linear_addr_gen.sv
module seg_linear_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W   = 16,
  parameter int unsigned OFF_W   = 32,
  parameter int unsigned SHIFT   = 4,
  parameter int unsigned LIMIT_W = 16,
  parameter int unsigned LIN_W   = 32,
  parameter int unsigned VEC_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_compat,
  input  logic [SEG_W-1:0] in_segment,
  input  logic [OFF_W-1:0] in_offset,
  input  logic             in_stack,
  output logic             out_addr_ok,
  output logic             out_fault,
  output logic [LIN_W-1:0] out_addr,
  output logic [VEC_W-1:0] out_vector,
  input  logic             out_ready
);
  localparam int unsigned SUM_W = SEG_W + SHIFT + 1;
  localparam int unsigned PAY_W = LIN_W + VEC_W;

  logic [SUM_W-1:0] seg_sum;
  logic [LIN_W-1:0] sum_lin;
  logic [LIN_W-1:0] pass_lin;
  logic             over;
  logic [VEC_W-1:0] vec_n;
  logic [LIN_W-1:0] addr_n;
  logic [1:0]       kind_n;
  logic [1:0]       kind_q;
  logic [PAY_W-1:0] pay_q;
  logic             accept;

  seg_base_adder #(.SEG_W(SEG_W), .SHIFT(SHIFT), .LIMIT_W(LIMIT_W)) u_add (
    .seg    (in_segment),
    .off_lo (in_offset[LIMIT_W-1:0]),
    .sum    (seg_sum)
  );

  offset_limit_check #(.OFF_W(OFF_W), .LIMIT_W(LIMIT_W), .VEC_W(VEC_W)) u_lim (
    .off    (in_offset),
    .compat (in_compat),
    .stack  (in_stack),
    .over   (over),
    .vector (vec_n)
  );

  generate
    if (LIN_W > SUM_W) begin : g_sum_pad
      assign sum_lin = {{(LIN_W-SUM_W){1'b0}}, seg_sum};
    end else begin : g_sum_cut
      assign sum_lin = seg_sum[LIN_W-1:0];
    end
    if (LIN_W > OFF_W) begin : g_off_pad
      assign pass_lin = {{(LIN_W-OFF_W){1'b0}}, in_offset};
    end else begin : g_off_cut
      assign pass_lin = in_offset[LIN_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!in_compat) begin
      addr_n = pass_lin;
      kind_n = RESP_ADDR;
    end else if (over) begin
      addr_n = '0;
      kind_n = RESP_FAULT;
    end else begin
      addr_n = sum_lin;
      kind_n = RESP_ADDR;
    end
  end

  resp_stage #(.DW(PAY_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (in_valid),
    .load_ready (in_ready),
    .load_data  ({addr_n, vec_n}),
    .load_kind  (kind_n),
    .hold_kind  (kind_q),
    .hold_data  (pay_q),
    .drain      (out_ready)
  );

  assign accept      = in_valid && in_ready;
  assign out_addr_ok = kind_q[0];
  assign out_fault   = kind_q[1];
  assign out_addr    = pay_q[PAY_W-1:VEC_W];
  assign out_vector  = pay_q[VEC_W-1:0];

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_addr_ok && out_fault));

  p_fault_noaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_addr == '0);

  p_vec_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_vector == VEC_W'(VEC_STACK_FAULT) ||
                   out_vector == VEC_W'(VEC_GP_FAULT)));

  p_bypass_nofault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_compat) |=> (out_addr_ok && !out_fault));

  p_resp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_addr_ok || out_fault));

  generate
    if (LIN_W > SUM_W) begin : g_upper_chk
      p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_compat) |=> out_addr[LIN_W-1:SUM_W] == '0);
    end
  endgenerate
endmodule

// File: tb/seg_linear_addr_gen_test.sv
module seg_linear_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_compat = 1'b0;
  logic [15:0] in_segment = '0;
  logic [31:0] in_offset = '0;
  logic        in_stack = 1'b0;
  logic        out_addr_ok;
  logic        out_fault;
  logic [31:0] out_addr;
  logic [7:0]  out_vector;
  logic        out_ready = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_linear_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_compat(in_compat), .in_segment(in_segment), .in_offset(in_offset),
    .in_stack(in_stack), .out_addr_ok(out_addr_ok), .out_fault(out_fault),
    .out_addr(out_addr), .out_vector(out_vector), .out_ready(out_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one request, let it be taken, sample the response at the next negedge.
  task automatic xfer(input logic c, input logic [15:0] s, input logic [31:0] o, input logic st);
    @(negedge clk);
    in_valid = 1'b1; in_compat = c; in_segment = s; in_offset = o; in_stack = st;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_addr(input string req, input logic [31:0] exp);
    chk({req, " ok"}, {31'd0, out_addr_ok}, 32'd1);
    chk({req, " fault"}, {31'd0, out_fault}, 32'd0);
    chk({req, " addr"}, out_addr, exp);
    chk({req, " vec"}, {24'd0, out_vector}, 32'd0);
  endtask

  task automatic expect_fault(input string req, input logic [7:0] vec);
    chk({req, " ok"}, {31'd0, out_addr_ok}, 32'd0);
    chk({req, " fault"}, {31'd0, out_fault}, 32'd1);
    chk({req, " addr"}, out_addr, 32'd0);
    chk({req, " vec"}, {24'd0, out_vector}, {24'd0, vec});
  endtask

  task automatic t_reset;
    chk("R9 ok", {31'd0, out_addr_ok}, 32'd0);
    chk("R9 fault", {31'd0, out_fault}, 32'd0);
    chk("R9 ready", {31'd0, in_ready}, 32'd1);
    chk("R9 addr", out_addr, 32'd0);
    chk("R9 vec", {24'd0, out_vector}, 32'd0);
  endtask

  task automatic t_basic;
    xfer(1'b1, 16'h0000, 32'h0000_0000, 1'b0); expect_addr("R1 zero", 32'h0);
    xfer(1'b1, 16'h1234, 32'h0000_0005, 1'b0); expect_addr("R1 a", 32'h12345);
    xfer(1'b1, 16'hB800, 32'h0000_0F9E, 1'b1); expect_addr("R1 b", 32'hB8F9E);
    xfer(1'b1, 16'h0001, 32'h0000_FFFF, 1'b0); expect_addr("R10 c", 32'h1000F);
  endtask

  task automatic t_carry;
    xfer(1'b1, 16'hFFFF, 32'h0000_FFFF, 1'b0); expect_addr("R2 max", 32'h10FFEF);
    chk("R3 upper", {21'd0, out_addr[31:21]}, 32'd0);
    xfer(1'b1, 16'hF000, 32'h0001_0000 - 1, 1'b0); expect_addr("R2 wrap", 32'h0FFFFF);
    xfer(1'b1, 16'hF001, 32'h0000_FFF0, 1'b0); expect_addr("R2 carry", 32'h100000);
  endtask

  task automatic t_fault;
    xfer(1'b1, 16'h0100, 32'h0001_0000, 1'b1); expect_fault("R5 stack", 8'd12);
    xfer(1'b1, 16'h0100, 32'h0001_0000, 1'b0); expect_fault("R5 gp", 8'd13);
    xfer(1'b1, 16'hFFFF, 32'h8000_0000, 1'b0); expect_fault("R4 high", 8'd13);
    xfer(1'b1, 16'h0000, 32'hFFFF_FFFF, 1'b1); expect_fault("R4 all", 8'd12);
  endtask

  task automatic t_bypass;
    xfer(1'b0, 16'hFFFF, 32'hDEAD_BEEF, 1'b1); expect_addr("R6 pass", 32'hDEAD_BEEF);
    xfer(1'b0, 16'h0000, 32'h0001_0000, 1'b0); expect_addr("R6 big", 32'h0001_0000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    xfer(1'b1, 16'h2000, 32'h0000_0010, 1'b0);
    expect_addr("R7 next", 32'h20010);
    in_valid = 1'b1; in_compat = 1'b1; in_segment = 16'h0000; in_offset = 32'h0002_0000; in_stack = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 ready low", {31'd0, in_ready}, 32'd0);
      expect_addr("R8 held", 32'h20010);
    end
    out_ready = 1'b1;
    #1;
    chk("R8 ready on drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_fault("R8 second", 8'd12);
    @(negedge clk);
    chk("R7 drained ok", {31'd0, out_addr_ok}, 32'd0);
    chk("R7 drained fault", {31'd0, out_fault}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_carry();
    t_fault();
    t_bypass();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule